// File: doc/BRIEF.md
# Packed Saturating Signed Subtractor

This block subtracts one packed vector from another, lane by lane, and treats every lane as a two's-complement signed integer. A result that falls outside the lane's signed range is clamped to the nearest limit instead of wrapping. Lanes are either 8 or 16 bits wide. The vector length in use is 128, 256 or 512 bits.

A per-lane write mask can be switched on. A lane whose mask bit is clear either keeps the previous destination contents or is written as zero. The bits above the active length follow a separate policy: they are either copied from the previous destination or cleared.

The caller presents both sources, the previous destination value and the control fields together with a one-cycle start strobe. The result is written to a destination register on the next clock edge and marked by a one-cycle valid pulse. The register then holds that result until the next start. The block produces no flags and raises no exceptions.

Top module: `psat_sub_unit`

## Requirements
- R1: When `elem_word_i`=0 (8-bit lanes), byte lane j (bits 8j+7:8j) receives A−B of the signed bytes. A true difference above 127 is written as 0x7F, and one below −128 is written as 0x80.
- R2: When `elem_word_i`=1 (16-bit lanes), word lane j (bits 16j+15:16j) receives A−B of the signed words. A true difference above 32767 is written as 0x7FFF, and one below −32768 is written as 0x8000.
- R3: `len_sel_i` sets the active length: 0 gives 128 bits, 1 gives 256 bits, and 2 or 3 give 512 bits. The active lane count is the active length divided by the lane width.
- R4: When `mask_en_i`=0, every active lane receives its saturated difference. When `mask_en_i`=1, mask bit j (counting from the least significant lane) set to 1 selects the difference for lane j.
- R5: When `mask_en_i`=1 and `zero_mode_i`=0, an active lane whose mask bit is 0 takes its value from `dest_old_i`.
- R6: When `mask_en_i`=1 and `zero_mode_i`=1, an active lane whose mask bit is 0 is written as all zeros.
- R7: When `clear_upper_i`=1, every result bit at or above the active length is 0. When `clear_upper_i`=0, those bits equal the matching bits of `dest_old_i`.
- R8: Mask bits at an index equal to or above the active lane count have no effect on the result.
- R9: A result is written to `dest_o` on the first rising edge at which `start_i`=1. `valid_o` is high for exactly the following cycle. `dest_o` does not change while `start_i` stays low.
- R10: A synchronous reset (`rst`=1 at a rising edge) clears `dest_o` to zero and drives `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sample inputs and compute on this edge |
| src_a_i | input | 512 | Minuend vector |
| src_b_i | input | 512 | Subtrahend vector |
| dest_old_i | input | 512 | Previous destination value |
| elem_word_i | input | 1 | 0 = 8-bit lanes, 1 = 16-bit lanes |
| len_sel_i | input | 2 | Active length code (0:128, 1:256, 2/3:512) |
| mask_en_i | input | 1 | Enable per-lane write mask |
| mask_i | input | 64 | Per-lane mask, bit j for lane j |
| zero_mode_i | input | 1 | Masked-off lanes: 0 keep old, 1 clear |
| clear_upper_i | input | 1 | Bits above active length: 0 keep old, 1 clear |
| dest_o | output | 512 | Registered destination |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
Every internal decision shows up in the destination word on the clock after the start strobe. A wrong lane-size select shifts the clamp points into the wrong bit positions. A wrong active-length count shows as upper bytes that are cleared or kept against the policy. A mask index off by one lane shows as a lane that moved, kept or zeroed in the wrong place. Saturation patterns are placed at both ends of the range, in the lowest lane and in the highest active lane, so that a sign or carry error in the extended difference appears within that single result.

// File: rtl/psat_pkg.sv
package psat_pkg;

    parameter int unsigned VEC_W = 512;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned NBYTE  = VEC_W / BYTE_W;
    localparam int unsigned NWORD  = VEC_W / WORD_W;
    localparam int unsigned CNT_W  = $clog2(NBYTE + 1);

    typedef enum logic {
        ES_BYTE = 1'b0,
        ES_WORD = 1'b1
    } elem_e;

    typedef enum logic [1:0] {
        LEN_128  = 2'd0,
        LEN_256  = 2'd1,
        LEN_512  = 2'd2,
        LEN_512B = 2'd3
    } len_e;

    typedef struct packed {
        elem_e elem;
        len_e  len;
        logic  mask_en;
        logic  zero_mode;
        logic  clear_upper;
    } ctrl_t;

    // Number of active bytes for a length code.
    function automatic logic [CNT_W-1:0] active_bytes(input len_e l);
        case (l)
            LEN_128: active_bytes = CNT_W'(128 / BYTE_W);
            LEN_256: active_bytes = CNT_W'(256 / BYTE_W);
            default: active_bytes = CNT_W'(NBYTE);
        endcase
    endfunction

    // Extended-width difference; the top two bits tell overflow direction.
    function automatic logic [BYTE_W-1:0] sat_sub_b(input logic [BYTE_W-1:0] a,
                                                    input logic [BYTE_W-1:0] b);
        logic [BYTE_W:0] d;
        d = {a[BYTE_W-1], a} - {b[BYTE_W-1], b};
        case (d[BYTE_W:BYTE_W-1])
            2'b01:   sat_sub_b = {1'b0, {(BYTE_W-1){1'b1}}};
            2'b10:   sat_sub_b = {1'b1, {(BYTE_W-1){1'b0}}};
            default: sat_sub_b = d[BYTE_W-1:0];
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] sat_sub_w(input logic [WORD_W-1:0] a,
                                                    input logic [WORD_W-1:0] b);
        logic [WORD_W:0] d;
        d = {a[WORD_W-1], a} - {b[WORD_W-1], b};
        case (d[WORD_W:WORD_W-1])
            2'b01:   sat_sub_w = {1'b0, {(WORD_W-1){1'b1}}};
            2'b10:   sat_sub_w = {1'b1, {(WORD_W-1){1'b0}}};
            default: sat_sub_w = d[WORD_W-1:0];
        endcase
    endfunction

endpackage

// File: rtl/psat_lanes.sv
module psat_lanes
    import psat_pkg::*;
(
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] diff_b_o,
    output logic [VEC_W-1:0] diff_w_o
);

    for (genvar j = 0; j < NBYTE; j++) begin : g_byte
        assign diff_b_o[j*BYTE_W +: BYTE_W] =
            sat_sub_b(a_i[j*BYTE_W +: BYTE_W], b_i[j*BYTE_W +: BYTE_W]);
    end

    for (genvar j = 0; j < NWORD; j++) begin : g_word
        assign diff_w_o[j*WORD_W +: WORD_W] =
            sat_sub_w(a_i[j*WORD_W +: WORD_W], b_i[j*WORD_W +: WORD_W]);
    end

endmodule

// File: rtl/psat_compose.sv
module psat_compose
    import psat_pkg::*;
(
    input  logic [VEC_W-1:0] diff_b_i,
    input  logic [VEC_W-1:0] diff_w_i,
    input  logic [VEC_W-1:0] old_i,
    input  logic [NBYTE-1:0] mask_i,
    input  ctrl_t            ctrl_i,
    output logic [VEC_W-1:0] next_o
);

    logic [CNT_W-1:0] n_act;
    logic             is_word;

    assign n_act   = active_bytes(ctrl_i.len);
    assign is_word = (ctrl_i.elem == ES_WORD);

    for (genvar k = 0; k < NBYTE; k++) begin : g_pos
        logic [BYTE_W-1:0] diff;
        logic [BYTE_W-1:0] prev;
        logic              mbit;
        logic              take;
        logic              active;

        assign diff   = is_word ? diff_w_i[k*BYTE_W +: BYTE_W]
                                : diff_b_i[k*BYTE_W +: BYTE_W];
        assign prev   = old_i[k*BYTE_W +: BYTE_W];
        assign mbit   = is_word ? mask_i[k/2] : mask_i[k];
        assign take   = !ctrl_i.mask_en || mbit;
        assign active = (CNT_W'(k) < n_act);

        always_comb begin
            if (!active)
                next_o[k*BYTE_W +: BYTE_W] = ctrl_i.clear_upper ? '0 : prev;
            else if (take)
                next_o[k*BYTE_W +: BYTE_W] = diff;
            else
                next_o[k*BYTE_W +: BYTE_W] = ctrl_i.zero_mode ? '0 : prev;
        end
    end

endmodule

// File: rtl/psat_sub_unit.sv
module psat_sub_unit
    import psat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [VEC_W-1:0] src_a_i,
    input  logic [VEC_W-1:0] src_b_i,
    input  logic [VEC_W-1:0] dest_old_i,
    input  logic             elem_word_i,
    input  logic [1:0]       len_sel_i,
    input  logic             mask_en_i,
    input  logic [NBYTE-1:0] mask_i,
    input  logic             zero_mode_i,
    input  logic             clear_upper_i,
    output logic [VEC_W-1:0] dest_o,
    output logic             valid_o
);

    ctrl_t            ctrl;
    logic [VEC_W-1:0] diff_b;
    logic [VEC_W-1:0] diff_w;
    logic [VEC_W-1:0] next_val;
    logic [VEC_W-1:0] dest_q;
    logic             valid_q;

    assign ctrl.elem        = elem_e'(elem_word_i);
    assign ctrl.len         = len_e'(len_sel_i);
    assign ctrl.mask_en     = mask_en_i;
    assign ctrl.zero_mode   = zero_mode_i;
    assign ctrl.clear_upper = clear_upper_i;

    psat_lanes u_lanes (
        .a_i      (src_a_i),
        .b_i      (src_b_i),
        .diff_b_o (diff_b),
        .diff_w_o (diff_w)
    );

    psat_compose u_compose (
        .diff_b_i (diff_b),
        .diff_w_i (diff_w),
        .old_i    (dest_old_i),
        .mask_i   (mask_i),
        .ctrl_i   (ctrl),
        .next_o   (next_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= start_i;
            if (start_i)
                dest_q <= next_val;
        end
    end

    assign dest_o  = dest_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/psat_sub_checker.sv
module psat_sub_checker
    import psat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [VEC_W-1:0] src_a_i,
    input logic [VEC_W-1:0] src_b_i,
    input logic             elem_word_i,
    input logic [1:0]       len_sel_i,
    input logic             mask_en_i,
    input logic [NBYTE-1:0] mask_i,
    input logic             zero_mode_i,
    input logic             clear_upper_i,
    input logic [VEC_W-1:0] dest_o,
    input logic             valid_o
);

    // R10: reset clears the outputs
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!valid_o && dest_o == '0));

    // R9: valid follows start by exactly one cycle
    assert_valid_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(dest_o));

    // R1: positive minus negative can never give a negative byte
    assert_pos_clamp_R1: assert property (@(posedge clk) disable iff (rst)
        (start_i && !elem_word_i && !mask_en_i && !src_a_i[7] && src_b_i[7])
        |=> !dest_o[7]);
    assert_neg_clamp_R1: assert property (@(posedge clk) disable iff (rst)
        (start_i && !elem_word_i && !mask_en_i && src_a_i[7] && !src_b_i[7] &&
         src_b_i[7:0] != 8'h00)
        |=> dest_o[7]);

    // R2: same for the lowest word lane
    assert_pos_clamp_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && elem_word_i && !mask_en_i && !src_a_i[15] && src_b_i[15])
        |=> !dest_o[15]);

    // R6: masked-off lane 0 in zero mode is cleared
    assert_zero_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (start_i && mask_en_i && zero_mode_i && !mask_i[0] && !elem_word_i)
        |=> dest_o[7:0] == 8'h00);

    // R7: clear policy with 128-bit length leaves the upper part zero
    assert_upper_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && clear_upper_i && len_sel_i == 2'd0)
        |=> dest_o[VEC_W-1:128] == '0);

endmodule

bind psat_sub_unit psat_sub_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .src_a_i       (src_a_i),
    .src_b_i       (src_b_i),
    .elem_word_i   (elem_word_i),
    .len_sel_i     (len_sel_i),
    .mask_en_i     (mask_en_i),
    .mask_i        (mask_i),
    .zero_mode_i   (zero_mode_i),
    .clear_upper_i (clear_upper_i),
    .dest_o        (dest_o),
    .valid_o       (valid_o)
);

// File: tb/psat_sub_unit_bench.sv
module psat_sub_unit_bench;
    import psat_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [VEC_W-1:0] src_a_i = '0;
    logic [VEC_W-1:0] src_b_i = '0;
    logic [VEC_W-1:0] dest_old_i = '0;
    logic             elem_word_i = 1'b0;
    logic [1:0]       len_sel_i = 2'd2;
    logic             mask_en_i = 1'b0;
    logic [NBYTE-1:0] mask_i = '0;
    logic             zero_mode_i = 1'b0;
    logic             clear_upper_i = 1'b0;
    logic [VEC_W-1:0] dest_o;
    logic             valid_o;

    int checks = 0;
    int failures = 0;
    logic [VEC_W-1:0] exp_q[$];
    string            tag_q[$];
    logic             done = 1'b0;

    always #10 clk = ~clk;

    psat_sub_unit u_psat_sub_unit (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .src_a_i       (src_a_i),
        .src_b_i       (src_b_i),
        .dest_old_i    (dest_old_i),
        .elem_word_i   (elem_word_i),
        .len_sel_i     (len_sel_i),
        .mask_en_i     (mask_en_i),
        .mask_i        (mask_i),
        .zero_mode_i   (zero_mode_i),
        .clear_upper_i (clear_upper_i),
        .dest_o        (dest_o),
        .valid_o       (valid_o)
    );

    function automatic logic [VEC_W-1:0] model(
        input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
        input logic [VEC_W-1:0] old, input logic word, input logic [1:0] len,
        input logic men, input logic [NBYTE-1:0] m, input logic zm, input logic clr);
        logic [VEC_W-1:0] r;
        int act;
        int w;
        int x;
        int hi;
        int lo_lim;
        act = (len == 2'd0) ? 128 : (len == 2'd1) ? 256 : 512;
        w = word ? 16 : 8;
        hi = word ? 32767 : 127;
        lo_lim = word ? -32768 : -128;
        r = '0;
        for (int j = 0; j < VEC_W / w; j++) begin
            int lo;
            lo = j * w;
            if (lo >= act) begin
                for (int i = 0; i < w; i++) r[lo+i] = clr ? 1'b0 : old[lo+i];
            end else if (!men || m[j]) begin
                if (word) x = int'($signed(a[lo +: 16])) - int'($signed(b[lo +: 16]));
                else      x = int'($signed(a[lo +: 8]))  - int'($signed(b[lo +: 8]));
                if (x > hi) x = hi;
                if (x < lo_lim) x = lo_lim;
                for (int i = 0; i < w; i++) r[lo+i] = x[i];
            end else begin
                for (int i = 0; i < w; i++) r[lo+i] = zm ? 1'b0 : old[lo+i];
            end
        end
        return r;
    endfunction

    task automatic drive(input string tag,
        input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
        input logic [VEC_W-1:0] old, input logic word, input logic [1:0] len,
        input logic men, input logic [NBYTE-1:0] m, input logic zm, input logic clr);
        @(negedge clk);
        src_a_i = a; src_b_i = b; dest_old_i = old;
        elem_word_i = word; len_sel_i = len; mask_en_i = men; mask_i = m;
        zero_mode_i = zm; clear_upper_i = clr; start_i = 1'b1;
        exp_q.push_back(model(a, b, old, word, len, men, m, zm, clr));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        start_i = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected valid: actual=1 expected=0");
            end else begin
                logic [VEC_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (dest_o !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, dest_o, e);
                end
            end
        end
    end

    function automatic logic [VEC_W-1:0] rnd();
        logic [VEC_W-1:0] v;
        for (int i = 0; i < VEC_W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [VEC_W-1:0] a, b, old, snap;
        repeat (3) @(negedge clk);
        checks++;
        if (dest_o !== '0 || valid_o !== 1'b0) begin
            failures++;
            $display("FAIL R10 reset state: actual=%h/%b expected=0/0", dest_o, valid_o);
        end
        rst = 1'b0;

        // R1 byte lanes, no overflow and both clamps
        a = {64{8'h10}}; b = {64{8'h03}};
        drive("R1 plain bytes", a, b, rnd(), 1'b0, 2'd2, 1'b0, '0, 1'b0, 1'b0);
        a = {32{8'h7F, 8'h64}}; b = {32{8'h80, 8'h9C}};
        drive("R1 positive clamp", a, b, rnd(), 1'b0, 2'd2, 1'b0, '0, 1'b0, 1'b0);
        a = {32{8'h80, 8'hC0}}; b = {32{8'h01, 8'h7F}};
        drive("R1 negative clamp", a, b, rnd(), 1'b0, 2'd2, 1'b0, '0, 1'b0, 1'b0);
        a = {32{8'h80, 8'h7F}}; b = {32{8'h00, 8'hFF}};
        drive("R1 boundary exact", a, b, rnd(), 1'b0, 2'd3, 1'b0, '0, 1'b0, 1'b0);
        // R2 word lanes
        a = {16{16'h7FFF, 16'h8000}}; b = {16{16'h8000, 16'h0001}};
        drive("R2 word clamps", a, b, rnd(), 1'b1, 2'd2, 1'b0, '0, 1'b0, 1'b0);
        a = {32{16'h00FF}}; b = {32{16'h0080}};
        drive("R2 no byte carry split", a, b, rnd(), 1'b1, 2'd2, 1'b0, '0, 1'b0, 1'b0);
        // R3 / R7 lengths and upper policy
        drive("R3 R7 len128 clear", rnd(), rnd(), rnd(), 1'b0, 2'd0, 1'b0, '0, 1'b0, 1'b1);
        drive("R3 R7 len256 keep", rnd(), rnd(), rnd(), 1'b1, 2'd1, 1'b0, '0, 1'b0, 1'b0);
        drive("R3 R7 len256 clear", rnd(), rnd(), rnd(), 1'b0, 2'd1, 1'b0, '0, 1'b0, 1'b1);
        drive("R3 len code 3", rnd(), rnd(), rnd(), 1'b1, 2'd3, 1'b0, '0, 1'b0, 1'b1);
        // R4 R5 R6 masks
        drive("R4 R5 merge bytes", rnd(), rnd(), rnd(), 1'b0, 2'd2, 1'b1,
              64'hA5A5_0F0F_3C3C_8001, 1'b0, 1'b0);
        drive("R4 R6 zero bytes", rnd(), rnd(), rnd(), 1'b0, 2'd2, 1'b1,
              64'h8000_0000_0000_0001, 1'b1, 1'b0);
        drive("R4 R5 merge words", rnd(), rnd(), rnd(), 1'b1, 2'd2, 1'b1,
              64'h0000_0000_9669_0F01, 1'b0, 1'b0);
        drive("R4 R6 zero words", rnd(), rnd(), rnd(), 1'b1, 2'd1, 1'b1,
              64'h0000_0000_0000_5A5A, 1'b1, 1'b1);
        // R8 out-of-range mask bits: two runs differing only there
        a = rnd(); b = rnd(); old = rnd();
        drive("R8 mask upper zeros", a, b, old, 1'b0, 2'd0, 1'b1,
              64'h0000_0000_0000_1234, 1'b1, 1'b0);
        drive("R8 mask upper ones", a, b, old, 1'b0, 2'd0, 1'b1,
              64'hFFFF_FFFF_FFFF_1234, 1'b1, 1'b0);
        drive("R8 word mask upper ones", a, b, old, 1'b1, 2'd0, 1'b1,
              64'hFFFF_FFFF_FFFF_FF35, 1'b0, 1'b1);
        // random mix
        for (int n = 0; n < 20; n++) begin
            drive("R1 R2 R4 random", rnd(), rnd(), rnd(), 1'($urandom), 2'($urandom),
                  1'($urandom), {$urandom, $urandom}, 1'($urandom), 1'($urandom));
        end
        idle(3);
        // R9 hold while start low, inputs changing
        snap = dest_o;
        src_a_i = rnd(); src_b_i = rnd(); dest_old_i = rnd();
        repeat (4) @(negedge clk);
        checks++;
        if (dest_o !== snap || valid_o !== 1'b0) begin
            failures++;
            $display("FAIL R9 hold: actual=%h expected=%h", dest_o, snap);
        end
        // R10 reset after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (dest_o !== '0 || valid_o !== 1'b0) begin
            failures++;
            $display("FAIL R10 reset after use: actual=%h/%b expected=0/0", dest_o, valid_o);
        end
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R9 missing results: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule